// File: doc/BRIEF.md
# Vertical Three-Line Sharpening Filter

This block sharpens an image along the sub-scan axis. For every main-scan position it receives three vertically aligned pixels. The centre pixel N comes from the line that is being corrected. Pixel A comes from the line before it and pixel B from the line after it. The surrounding system takes B straight from the incoming scan data, N from a one-line delay and A from a two-line delay. The block forms the vertical second difference 2N − (A + B), scales it by a programmable coefficient K, and adds the result back to N. The result is clamped to the pixel range.

The coefficient is an unsigned fixed-point number and is captured together with each accepted pixel triple. Firmware can therefore change it between lines without corrupting pixels that are already in flight. The datapath has two register stages. The first stage forms the difference. The second stage does the scaling, the rounding, the final add and the clamp. The output strobe follows the input strobe after the same two clocks.

Top module: `lap3_sharpen`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, `out_vld` is 0 and `out_pix` is 0.
- R2: `out_vld` equals `in_vld` delayed by exactly two rising clock edges. Each accepted triple gives exactly one output, and outputs appear in the order the triples were accepted.
- R3: For an accepted triple, `out_pix` = clamp(N + round(K · (2N − (A + B)))), where A = `in_prev`, N = `in_ctr`, B = `in_next`, and all three are unsigned.
- R4: `coef` holds K as unsigned fixed point: bits [7:4] are the integer part and bits [3:0] are sixteenths. The scaled term is floor((coef · D + 8) / 16), where D = 2N − (A + B). A value exactly halfway rounds toward +infinity, so D = 8 with coef = 1 gives +1 and D = −8 with coef = 1 gives 0.
- R5: When the unclamped sum exceeds 255, `out_pix` is 255.
- R6: When the unclamped sum is below 0, `out_pix` is 0.
- R7: When `coef` is 0, `out_pix` equals N exactly.
- R8: The coefficient that applies to a pixel is the value of `coef` on the clock where that pixel's `in_vld` is high. Values of `coef` on other cycles have no effect on it.
- R9: On cycles where `out_vld` is 0, `out_pix` keeps its previous value. Pixel and coefficient inputs presented with `in_vld` low have no effect on any later output.
- R10: When A, N and B are equal, `out_pix` equals N for every coefficient.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | The pixel triple and coefficient on this cycle are accepted |
| in_prev | input | 8 | Pixel A from the line before the centre line |
| in_ctr | input | 8 | Pixel N from the centre line |
| in_next | input | 8 | Pixel B from the line after the centre line |
| coef | input | 8 | Sharpening coefficient K, 4 integer and 4 fraction bits |
| out_vld | output | 1 | `out_pix` carries a new result |
| out_pix | output | 8 | Sharpened, clamped centre pixel |

## Verification
The bench builds the block with its defaults: 8-bit pixels, a coefficient with 4 integer and 4 fraction bits, and round-to-nearest selected. With these values the largest coefficient (just under 16) times the extreme differences of ±510 drives the sum far past both clamp limits. The 1/16 step lets single-count differences land exactly on the rounding halfway point, in both the positive and the negative direction. Gaps of random width between pixels, with random data presented while the strobe is low, exercise the hold behaviour, the coefficient capture and the two-clock latency.

// File: rtl/lap_pkg.sv
package lap_pkg;

   // Rounding applied to the scaled difference before the final add
   typedef enum logic {
      RND_TRUNC   = 1'b0,   // floor (arithmetic shift only)
      RND_NEAREST = 1'b1    // nearest, halfway toward +infinity
   } rnd_mode_e;

endpackage

// File: rtl/lap_diff.sv
// Stage 1: registers the vertical second difference 2N-(A+B)
// together with the centre pixel and the coefficient of the same triple.
module lap_diff #(
   parameter int PIX_W = 8,
   parameter int KW    = 8,
   localparam int DW   = PIX_W + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 vld_i,
   input  logic [PIX_W-1:0]     prev_i,
   input  logic [PIX_W-1:0]     ctr_i,
   input  logic [PIX_W-1:0]     next_i,
   input  logic [KW-1:0]        k_i,
   output logic                 vld_o,
   output logic signed [DW-1:0] diff_o,
   output logic [PIX_W-1:0]     ctr_o,
   output logic [KW-1:0]        k_o
);

   logic signed [DW-1:0] ctr_x2;
   logic signed [DW-1:0] outer_sum;
   logic signed [DW-1:0] diff_c;

   assign ctr_x2    = $signed({1'b0, ctr_i, 1'b0});
   assign outer_sum = $signed({2'b00, prev_i}) + $signed({2'b00, next_i});
   assign diff_c    = ctr_x2 - outer_sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         diff_o <= '0;
         ctr_o  <= '0;
         k_o    <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            diff_o <= diff_c;
            ctr_o  <= ctr_i;
            k_o    <= k_i;
         end
      end
   end

endmodule

// File: rtl/lap_scale.sv
// Combinational: scales the signed difference by the unsigned
// fixed-point coefficient and drops the fraction bits.
module lap_scale
   import lap_pkg::*;
#(
   parameter int        PIX_W  = 8,
   parameter int        KW     = 8,
   parameter int        K_FRAC = 4,
   parameter rnd_mode_e RND    = RND_NEAREST,
   localparam int       DW     = PIX_W + 2,
   localparam int       PW     = DW + KW + 1
) (
   input  logic signed [DW-1:0] diff_i,
   input  logic [KW-1:0]        k_i,
   output logic signed [PW-1:0] term_o
);

   logic signed [PW-1:0] d_ext;
   logic signed [PW-1:0] k_ext;
   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] biased;

   assign d_ext = PW'(diff_i);
   assign k_ext = $signed(PW'(k_i));
   assign prod  = d_ext * k_ext;

   generate
      if (K_FRAC == 0) begin : g_int_only
         assign biased = prod;
         assign term_o = prod;
      end else if (RND == RND_TRUNC) begin : g_floor
         assign biased = prod;
         assign term_o = biased >>> K_FRAC;
      end else begin : g_nearest
         localparam int HALF = 1 << (K_FRAC - 1);
         assign biased = prod + PW'(HALF);
         assign term_o = biased >>> K_FRAC;
      end
   endgenerate

endmodule

// File: rtl/lap_merge.sv
// Combinational: adds the scaled term to the centre pixel and clamps
// the signed sum into the unsigned pixel range.
module lap_merge #(
   parameter int  PIX_W = 8,
   parameter int  TW    = 19,
   localparam int SW    = TW + 1
) (
   input  logic [PIX_W-1:0]     ctr_i,
   input  logic signed [TW-1:0] term_i,
   output logic [PIX_W-1:0]     pix_o
);

   localparam logic signed [SW-1:0] PIX_MAX = SW'((1 << PIX_W) - 1);

   logic signed [SW-1:0] sum;

   assign sum = SW'(term_i) + $signed(SW'(ctr_i));

   always_comb begin
      if (sum < 0)
         pix_o = '0;
      else if (sum > PIX_MAX)
         pix_o = '1;
      else
         pix_o = sum[PIX_W-1:0];
   end

endmodule

// File: rtl/lap3_sharpen.sv
// Vertical three-line sharpening: out = clamp(N + K*(2N-(A+B))).
module lap3_sharpen
   import lap_pkg::*;
#(
   parameter int        PIX_W  = 8,
   parameter int        K_INT  = 4,
   parameter int        K_FRAC = 4,
   parameter rnd_mode_e RND    = RND_NEAREST,
   localparam int       KW     = K_INT + K_FRAC,
   localparam int       DW     = PIX_W + 2,
   localparam int       PW     = DW + KW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [PIX_W-1:0] in_prev,
   input  logic [PIX_W-1:0] in_ctr,
   input  logic [PIX_W-1:0] in_next,
   input  logic [KW-1:0]    coef,
   output logic             out_vld,
   output logic [PIX_W-1:0] out_pix
);

   initial begin : param_check
      assert (PIX_W >= 2 && PIX_W <= 16)
         else $fatal(1, "lap3_sharpen: PIX_W must be 2..16");
      assert (K_INT >= 0 && K_FRAC >= 0 && KW >= 1 && KW <= 16)
         else $fatal(1, "lap3_sharpen: coefficient width must be 1..16");
   end

   logic                 s1_vld;
   logic signed [DW-1:0] s1_diff;
   logic [PIX_W-1:0]     s1_ctr;
   logic [KW-1:0]        s1_k;
   logic signed [PW-1:0] s2_term;
   logic [PIX_W-1:0]     s2_pix;

   lap_diff #(
      .PIX_W (PIX_W),
      .KW    (KW)
   ) u_diff (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (in_vld),
      .prev_i (in_prev),
      .ctr_i  (in_ctr),
      .next_i (in_next),
      .k_i    (coef),
      .vld_o  (s1_vld),
      .diff_o (s1_diff),
      .ctr_o  (s1_ctr),
      .k_o    (s1_k)
   );

   lap_scale #(
      .PIX_W  (PIX_W),
      .KW     (KW),
      .K_FRAC (K_FRAC),
      .RND    (RND)
   ) u_scale (
      .diff_i (s1_diff),
      .k_i    (s1_k),
      .term_o (s2_term)
   );

   lap_merge #(
      .PIX_W (PIX_W),
      .TW    (PW)
   ) u_merge (
      .ctr_i  (s1_ctr),
      .term_i (s2_term),
      .pix_o  (s2_pix)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_pix <= '0;
      end else begin
         out_vld <= s1_vld;
         if (s1_vld)
            out_pix <= s2_pix;
      end
   end

endmodule

// File: rtl/lap3_sharpen_chk.sv
// Property checker attached to every lap3_sharpen instance.
module lap3_sharpen_chk #(
   parameter int PIX_W = 8,
   parameter int KW    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_vld,
   input logic [PIX_W-1:0] in_prev,
   input logic [PIX_W-1:0] in_ctr,
   input logic [PIX_W-1:0] in_next,
   input logic [KW-1:0]    coef,
   input logic             out_vld,
   input logic [PIX_W-1:0] out_pix
);

   // edges seen since reset release, saturating at 2
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since_rst <= 2'd0;
      else if (since_rst != 2'd2)
         since_rst <= since_rst + 2'd1;
   end

   AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd2) |-> (out_vld == $past(in_vld, 2))); // R2

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld |-> $stable(out_pix)); // R9

   AST_ZERO_COEF: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd2 && $past(in_vld, 2) && $past(coef, 2) == '0)
      |-> (out_pix == $past(in_ctr, 2))); // R7

   AST_FLAT_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd2 && $past(in_vld, 2)
       && $past(in_prev, 2) == $past(in_ctr, 2)
       && $past(in_next, 2) == $past(in_ctr, 2))
      |-> (out_pix == $past(in_ctr, 2))); // R10

endmodule

bind lap3_sharpen lap3_sharpen_chk #(
   .PIX_W (PIX_W),
   .KW    (KW)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .in_vld  (in_vld),
   .in_prev (in_prev),
   .in_ctr  (in_ctr),
   .in_next (in_next),
   .coef    (coef),
   .out_vld (out_vld),
   .out_pix (out_pix)
);

// File: tb/test_lap3_sharpen.sv
`timescale 1ns/1ps
module test_lap3_sharpen;

   localparam int PIX_W = 8;
   localparam int KW    = 8;

   typedef struct {
      int    pix;
      int    due;
      string req;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_vld = 1'b0;
   logic [PIX_W-1:0] in_prev = '0;
   logic [PIX_W-1:0] in_ctr = '0;
   logic [PIX_W-1:0] in_next = '0;
   logic [KW-1:0]    coef = '0;
   logic             out_vld;
   logic [PIX_W-1:0] out_pix;

   int   checks = 0;
   int   errors = 0;
   int   cyc = 0;
   int   last_pix = 0;
   bit   mon_on = 1'b0;
   exp_t sb[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   lap3_sharpen i_lap3_sharpen (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (in_vld),
      .in_prev (in_prev),
      .in_ctr  (in_ctr),
      .in_next (in_next),
      .coef    (coef),
      .out_vld (out_vld),
      .out_pix (out_pix)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic int model(input int a, input int n, input int b, input int k);
      int d, p, r, s;
      d = 2 * n - a - b;
      p = k * d;
      r = (p + 8) >>> 4;
      s = n + r;
      if (s < 0) s = 0;
      if (s > 255) s = 255;
      return s;
   endfunction

   task automatic send(input int a, input int n, input int b, input int k, input string req);
      exp_t e;
      @(negedge clk);
      in_vld  = 1'b1;
      in_prev = PIX_W'(a);
      in_ctr  = PIX_W'(n);
      in_next = PIX_W'(b);
      coef    = KW'(k);
      e.pix = model(a, n, b, k);
      e.due = cyc + 2;
      e.req = req;
      sb.push_back(e);
   endtask

   // idle cycles: random pixels and coefficient with the strobe low (R8, R9)
   task automatic idle(input int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         in_vld  = 1'b0;
         in_prev = PIX_W'($urandom);
         in_ctr  = PIX_W'($urandom);
         in_next = PIX_W'($urandom);
         coef    = KW'($urandom);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // monitor: pops the scoreboard whenever a result appears
   always @(negedge clk) begin
      if (mon_on && rst_n) begin
         if (out_vld) begin
            if (sb.size() == 0) begin
               check(1'b0, "R2 unexpected out_vld", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(cyc == e.due, "R2 latency", cyc, e.due);
               check(int'(out_pix) == e.pix, e.req, int'(out_pix), e.pix);
            end
            last_pix = int'(out_pix);
         end else begin
            check(int'(out_pix) == last_pix, "R9 hold while idle", int'(out_pix), last_pix);
         end
      end
   end

   initial begin : watchdog
      #400000;
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin : stim
      in_vld = 1'b1;   // strobe high during reset must not leak through
      repeat (3) @(negedge clk);
      check(out_vld == 1'b0, "R1 reset out_vld", int'(out_vld), 0);
      check(out_pix == '0, "R1 reset out_pix", int'(out_pix), 0);
      in_vld = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_vld == 1'b0, "R1 first clock out_vld", int'(out_vld), 0);
      check(out_pix == '0, "R1 first clock out_pix", int'(out_pix), 0);
      mon_on = 1'b1;

      // R7: zero coefficient passes the centre pixel
      send(0, 77, 255, 0, "R7 zero coef");
      send(255, 3, 255, 0, "R7 zero coef");
      send(10, 200, 0, 0, "R7 zero coef");
      // R10: flat column unchanged at any gain
      send(90, 90, 90, 255, "R10 flat column");
      send(0, 0, 0, 200, "R10 flat column");
      send(255, 255, 255, 16, "R10 flat column");
      idle(3);
      // R3/R4: rounding at halfway points, coef = 1/16
      send(92, 100, 100, 1, "R4 d=+8 rounds up");
      send(93, 100, 100, 1, "R4 d=+7 rounds down");
      send(108, 100, 100, 1, "R4 d=-8 rounds to 0");
      send(109, 100, 100, 1, "R4 d=-9 rounds to -1");
      send(100, 100, 90, 24, "R3 gain 1.5");
      // R5/R6: saturation
      send(0, 128, 0, 16, "R5 clamp high");
      send(0, 255, 0, 255, "R5 clamp high");
      send(255, 0, 255, 16, "R6 clamp low");
      send(255, 100, 255, 255, "R6 clamp low");
      // R8: coefficient sampled with its pixel; it changes during the gap
      send(60, 100, 60, 32, "R8 coef captured");
      idle(1);
      send(60, 100, 60, 8, "R8 coef captured");
      idle(2);

      // R3: random sweep with random gaps
      for (int i = 0; i < 400; i++) begin
         send(int'($urandom_range(255)), int'($urandom_range(255)),
              int'($urandom_range(255)), int'($urandom_range(255)), "R3 random");
         if ($urandom_range(3) == 0) idle(int'($urandom_range(3)) + 1);
      end
      idle(5);
      check(sb.size() == 0, "R2 all results delivered", sb.size(), 0);
      finish_run();
   end

endmodule